// File: doc/BRIEF.md
# Framer Error Counter and Interrupt Control

This block gathers the performance event pulses of a line framer into six saturating counters and manages the framer's interrupt line and its signal-loss alarm pin. A small register port lets software program a control word and an interrupt enable mask, and read back the control word, the mask and the sticky interrupt status. A separate select input picks which counter appears on the counter readback bus.

The control word has several functions. One bit starts a software reset lasting a fixed number of cycles, and another acknowledges interrupts; both clear themselves. A suspend bit silences the interrupt line and stops it from latching anything. A counter-clear bit holds every counter at zero while it is set. A sample bit switches the readable counters to one-second snapshots taken on the tick input. The last bit chooses whether the alarm pin shows loss of signal alone or loss of signal combined with loss of frame. The interrupt output is an open-drain style pull-down request: while it is 1 the pad is driven low, and while it is 0 the pad floats.

Top module: `perf_err_ctl`

## Requirements
- R1: Each bit of `ev_i` has its own counter, which adds one on every clock edge where the bit is 1. The bit order is 0 alignment change, 1 frame lost, 2 bipolar violation, 3 CRC error, 4 severely errored frame and 5 multiframe out of sync. `cnt_sel` values 0 to 5 read those counters and values 6 and 7 read zero.
- R2: A counter that reaches all-ones (255 at the default width) stays there and does not wrap.
- R3: While control bit 3 (counter clear) is 1, every counter is cleared at each clock edge and reads zero, starting from the edge after the bit is written.
- R4: While control bit 4 (sample) is 1, a `sec_tick` edge copies each live count, plus that cycle's event, into a held copy and restarts the live count at zero. The readback then shows the held copy.
- R5: Writing control bit 0 as 1 starts a software reset that lasts 4 cycles. During that window bit 0 reads 1, register writes are ignored, and the counters, the status, the enable mask and all control bits are cleared. Bit 0 then reads 0.
- R6: The interrupt status (address 2) is sticky. Each `int_src` bit sets its status bit, and the bit stays set until it is acknowledged or reset.
- R7: Writing control bit 1 as 1 (with bit 0 at 0) clears all status bits at that edge. Bit 1 always reads 0.
- R8: While control bit 2 (suspend) is 1, `irq_pull` is 0 and `int_src` has no effect on the status.
- R9: `irq_pull` is 1 exactly when suspend is 0 and some status bit is set whose enable bit (address 1) is also set.
- R10: With control bit 5 at 1, `los_alarm` follows `los_i` only. With bit 5 at 0, it is `los_i` OR `lof_i`.
- R11: After `rst_n` is low, all registers, counters and `irq_pull` read zero.
- R12: Register addresses are 0 for control, 1 for enable mask and 2 for status. Address 3 reads zero, and writes to addresses 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_i | input | N_EV (6) | Event pulses, one per counter |
| sec_tick | input | 1 | One-second tick pulse |
| int_src | input | N_INT (8) | Interrupt source pulses |
| los_i | input | 1 | Loss-of-signal state |
| lof_i | input | 1 | Loss-of-frame state |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| cnt_sel | input | 3 | Counter readback select |
| cnt_rdata | output | CNT_W (8) | Selected counter value |
| irq_pull | output | 1 | 1 = drive interrupt pad low, 0 = high impedance |
| los_alarm | output | 1 | Alarm pin |

## Verification
A live counter holding a wrong value shows on `cnt_rdata` in the cycle right after the edge that corrupted it, but only when that counter is selected. In sample mode the same fault stays hidden until the next tick moves it into the held copy. A status bit stuck at 0 or at 1 shows on the status read, and on `irq_pull` once its enable is set. A reset window that is too long or too short shows as bit 0 of the control read staying high for the wrong number of cycles, or as a write that takes effect when it should be ignored.

// File: rtl/perf_err_pkg.sv
package perf_err_pkg;
  localparam int DEF_N_EV    = 6;
  localparam int DEF_N_INT   = 8;
  localparam int DEF_CNT_W   = 8;
  localparam int DEF_RST_LEN = 4;
  localparam int REG_W       = 8;

  // control word bit positions (software-visible)
  localparam int CB_SRST    = 0;
  localparam int CB_ACK     = 1;
  localparam int CB_SUSP    = 2;
  localparam int CB_CCLR    = 3;
  localparam int CB_SAMP    = 4;
  localparam int CB_LOSONLY = 5;

  typedef enum logic [1:0] {
    A_CTL  = 2'd0,
    A_EN   = 2'd1,
    A_STAT = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic los_only;
    logic sample;
    logic cnt_clr;
    logic suspend;
  } ctl_t;

  function automatic ctl_t unpack_ctl(input logic [REG_W-1:0] w);
    ctl_t c;
    c.los_only = w[CB_LOSONLY];
    c.sample   = w[CB_SAMP];
    c.cnt_clr  = w[CB_CCLR];
    c.suspend  = w[CB_SUSP];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] pack_ctl(input ctl_t c, input logic busy);
    logic [REG_W-1:0] r;
    r = '0;
    r[CB_SRST]    = busy;
    r[CB_SUSP]    = c.suspend;
    r[CB_CCLR]    = c.cnt_clr;
    r[CB_SAMP]    = c.sample;
    r[CB_LOSONLY] = c.los_only;
    return r;
  endfunction
endpackage

// File: rtl/perf_evt_counter.sv
module perf_evt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         sample_mode,
  input  logic         tick,
  input  logic         ev,
  output logic [W-1:0] live_q,
  output logic [W-1:0] rd_val
);
  localparam logic [W-1:0] TOP = '1;

  function automatic logic [W-1:0] sat_inc(input logic [W-1:0] v, input logic inc);
    return (inc && v != TOP) ? v + W'(1) : v;
  endfunction

  logic [W-1:0] hold_q;
  logic         snap;

  assign snap = sample_mode & tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      hold_q <= '0;
    end else if (clr) begin
      live_q <= '0;
      hold_q <= '0;
    end else if (snap) begin
      hold_q <= sat_inc(live_q, ev);
      live_q <= '0;
    end else begin
      live_q <= sat_inc(live_q, ev);
    end
  end

  assign rd_val = sample_mode ? hold_q : live_q;
endmodule

// File: rtl/perf_srst_seq.sv
module perf_srst_seq #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic busy
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             left_q <= '0;
    else if (trig)          left_q <= CW'(LEN);
    else if (left_q != '0)  left_q <= left_q - CW'(1);
  end

  assign busy = (left_q != '0);
endmodule

// File: rtl/perf_irq_ctl.sv
module perf_irq_ctl #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         suspend,
  input  logic [N-1:0] src,
  input  logic [N-1:0] en,
  output logic [N-1:0] status,
  output logic         irq_pull
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        status <= '0;
    else if (clr)      status <= '0;
    else if (!suspend) status <= status | src;
  end

  assign irq_pull = !suspend && (|(status & en));
endmodule

// File: rtl/perf_err_ctl.sv
module perf_err_ctl
  import perf_err_pkg::*;
#(
  parameter int N_EV    = DEF_N_EV,
  parameter int N_INT   = DEF_N_INT,
  parameter int CNT_W   = DEF_CNT_W,
  parameter int RST_LEN = DEF_RST_LEN,
  parameter int SEL_W   = $clog2(N_EV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EV-1:0]  ev_i,
  input  logic             sec_tick,
  input  logic [N_INT-1:0] int_src,
  input  logic             los_i,
  input  logic             lof_i,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [SEL_W-1:0] cnt_sel,
  output logic [CNT_W-1:0] cnt_rdata,
  output logic             irq_pull,
  output logic             los_alarm
);
  ctl_t             ctl_q;
  logic [N_INT-1:0] en_q;
  logic [N_INT-1:0] status;
  logic             rst_busy;
  logic             wr_ctl, wr_en;
  logic             srst_trig, ack_pulse;
  logic             cnt_clear_any, status_clr;
  logic [CNT_W-1:0] rd_vals [N_EV];
  logic [N_EV*CNT_W-1:0] live_flat;

  // named internal events
  assign wr_ctl        = reg_we && (reg_addr == A_CTL) && !rst_busy;
  assign wr_en         = reg_we && (reg_addr == A_EN)  && !rst_busy;
  assign srst_trig     = wr_ctl && reg_wdata[CB_SRST];
  assign ack_pulse     = wr_ctl && reg_wdata[CB_ACK] && !reg_wdata[CB_SRST];
  assign cnt_clear_any = rst_busy || ctl_q.cnt_clr;
  assign status_clr    = rst_busy || ack_pulse;

  perf_srst_seq #(.LEN(RST_LEN)) u_srst (
    .clk  (clk),
    .rst_n(rst_n),
    .trig (srst_trig),
    .busy (rst_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      en_q  <= '0;
    end else if (rst_busy || srst_trig) begin
      ctl_q <= '0;
      en_q  <= '0;
    end else if (wr_ctl) begin
      ctl_q <= unpack_ctl(reg_wdata);
    end else if (wr_en) begin
      en_q  <= reg_wdata[N_INT-1:0];
    end
  end

  for (genvar g = 0; g < N_EV; g++) begin : g_cnt
    perf_evt_counter #(.W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (cnt_clear_any),
      .sample_mode(ctl_q.sample),
      .tick       (sec_tick),
      .ev         (ev_i[g]),
      .live_q     (live_flat[g*CNT_W +: CNT_W]),
      .rd_val     (rd_vals[g])
    );
  end

  perf_irq_ctl #(.N(N_INT)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (status_clr),
    .suspend (ctl_q.suspend),
    .src     (int_src),
    .en      (en_q),
    .status  (status),
    .irq_pull(irq_pull)
  );

  always_comb begin
    cnt_rdata = '0;
    for (int i = 0; i < N_EV; i++)
      if (cnt_sel == SEL_W'(i)) cnt_rdata = rd_vals[i];
  end

  always_comb begin
    case (reg_addr)
      A_CTL:   reg_rdata = pack_ctl(ctl_q, rst_busy);
      A_EN:    reg_rdata = REG_W'(en_q);
      A_STAT:  reg_rdata = REG_W'(status);
      default: reg_rdata = '0;
    endcase
  end

  assign los_alarm = los_i | (lof_i & ~ctl_q.los_only);
endmodule

// File: rtl/perf_err_chk.sv
module perf_err_chk #(
  parameter int N_EV  = 6,
  parameter int N_INT = 8,
  parameter int CNT_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  busy,
  input logic                  trig,
  input logic                  ack,
  input logic                  cnt_clear_any,
  input logic                  suspend,
  input logic                  sample,
  input logic                  los_only,
  input logic                  cnt_clr,
  input logic                  tick,
  input logic                  status_clr,
  input logic [N_INT-1:0]      status,
  input logic                  irq_pull,
  input logic                  los_i,
  input logic                  los_alarm,
  input logic [N_EV*CNT_W-1:0] live_flat
);
  localparam logic [CNT_W-1:0] TOP = '1;

  p_trig_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> busy);

  p_busy_defaults_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!suspend && !sample && !los_only && !cnt_clr));

  p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear_any |=> (live_flat == '0));

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (status == '0));

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !status_clr |=> ((status & $past(status)) == $past(status)));

  p_susp_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |-> !irq_pull);

  p_susp_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend && !status_clr) |=> $stable(status));

  p_los_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (los_only && !los_i) |-> !los_alarm);

  for (genvar g = 0; g < N_EV; g++) begin : g_sat
    p_no_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (live_flat[g*CNT_W +: CNT_W] == TOP && !cnt_clear_any && !(sample && tick))
        |=> (live_flat[g*CNT_W +: CNT_W] == TOP));
  end
endmodule

bind perf_err_ctl perf_err_chk #(.N_EV(N_EV), .N_INT(N_INT), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (rst_busy),
  .trig         (srst_trig),
  .ack          (ack_pulse),
  .cnt_clear_any(cnt_clear_any),
  .suspend      (ctl_q.suspend),
  .sample       (ctl_q.sample),
  .los_only     (ctl_q.los_only),
  .cnt_clr      (ctl_q.cnt_clr),
  .tick         (sec_tick),
  .status_clr   (status_clr),
  .status       (status),
  .irq_pull     (irq_pull),
  .los_i        (los_i),
  .los_alarm    (los_alarm),
  .live_flat    (live_flat)
);

// File: tb/sim_perf_err_ctl.sv
`timescale 1ns/1ps
module sim_perf_err_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] ev_i = '0;
  logic       sec_tick = 1'b0;
  logic [7:0] int_src = '0;
  logic       los_i = 1'b0, lof_i = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [2:0] cnt_sel = '0;
  logic [7:0] cnt_rdata;
  logic       irq_pull, los_alarm;

  always #2.5 clk = ~clk;

  perf_err_ctl u0 (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .sec_tick(sec_tick), .int_src(int_src),
    .los_i(los_i), .lof_i(lof_i), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_sel(cnt_sel),
    .cnt_rdata(cnt_rdata), .irq_pull(irq_pull), .los_alarm(los_alarm)
  );

  int    checks = 0, fails = 0;
  bit    done = 0;
  string cur_req = "R11";

  // reference model state
  logic [7:0] m_live [6];
  logic [7:0] m_hold [6];
  logic [7:0] m_st, m_en;
  logic       m_susp, m_cclr, m_samp, m_losonly;
  int         m_rcnt;

  function automatic logic [7:0] sat_add(input logic [7:0] v, input logic inc);
    if (inc && v != 8'hFF) return v + 8'd1;
    return v;
  endfunction

  function automatic logic [7:0] exp_reg(input logic [1:0] a);
    case (a)
      2'd0: return {2'b00, m_losonly, m_samp, m_cclr, m_susp, 1'b0, (m_rcnt != 0)};
      2'd1: return m_en;
      2'd2: return m_st;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_cnt(input logic [2:0] s);
    if (s > 3'd5) return 8'h00;
    return m_samp ? m_hold[s] : m_live[s];
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 6; i++) begin m_live[i] = '0; m_hold[i] = '0; end
    m_st = '0; m_en = '0; m_susp = 0; m_cclr = 0; m_samp = 0; m_losonly = 0; m_rcnt = 0;
  endtask

  task automatic step(input logic [5:0] ev, input logic tk, input logic [7:0] src,
                      input logic we, input logic [1:0] ad, input logic [7:0] wd);
    logic b, trig, ack, clrc;
    @(negedge clk);
    ev_i = ev; sec_tick = tk; int_src = src; reg_we = we; reg_addr = ad; reg_wdata = wd;
    cnt_sel = 3'($urandom_range(0, 7));
    los_i = 1'($urandom); lof_i = 1'($urandom);
    @(posedge clk);
    b    = (m_rcnt != 0);
    trig = we && ad == 2'd0 && !b && wd[0];
    ack  = we && ad == 2'd0 && !b && wd[1] && !wd[0];
    clrc = b || m_cclr;
    for (int i = 0; i < 6; i++) begin
      if (clrc) begin m_live[i] = '0; m_hold[i] = '0; end
      else if (m_samp && tk) begin m_hold[i] = sat_add(m_live[i], ev[i]); m_live[i] = '0; end
      else m_live[i] = sat_add(m_live[i], ev[i]);
    end
    if (b || ack) m_st = '0;
    else if (!m_susp) m_st = m_st | src;
    if (b || trig) begin
      m_susp = 0; m_cclr = 0; m_samp = 0; m_losonly = 0; m_en = '0;
    end else if (we && ad == 2'd0) begin
      m_susp = wd[2]; m_cclr = wd[3]; m_samp = wd[4]; m_losonly = wd[5];
    end else if (we && ad == 2'd1) begin
      m_en = wd;
    end
    if (trig) m_rcnt = 4;
    else if (b) m_rcnt = m_rcnt - 1;
    #1;
    chk(cnt_rdata, exp_cnt(cnt_sel), "counter readback");
    chk(reg_rdata, exp_reg(reg_addr), "register readback");
    chk({7'b0, irq_pull}, {7'b0, (|(m_st & m_en)) && !m_susp}, "irq_pull");
    chk({7'b0, los_alarm}, {7'b0, los_i | (lof_i & !m_losonly)}, "los_alarm");
  endtask

  function automatic logic [5:0] rnd_ev(input int pct);
    logic [5:0] e;
    for (int i = 0; i < 6; i++) e[i] = ($urandom_range(0, 99) < pct);
    return e;
  endfunction

  task automatic idle(input int n, input int pct, input int tick_every);
    for (int k = 0; k < n; k++)
      step(rnd_ev(pct), (tick_every > 0) && (k % tick_every == tick_every - 1), 8'h00,
           0, 2'($urandom_range(0, 3)), 8'h00);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    step(rnd_ev(30), 0, 8'h00, 1, a, d);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    model_reset();
    // R11: reset state
    cur_req = "R11";
    repeat (3) @(posedge clk);
    #1;
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a); #0.1;
      chk(reg_rdata, 8'h00, "reset register");
    end
    for (int s = 0; s < 6; s++) begin
      cnt_sel = 3'(s); #0.1;
      chk(cnt_rdata, 8'h00, "reset counter");
    end
    chk({7'b0, irq_pull}, 8'h00, "reset irq");
    @(negedge clk); rst_n = 1'b1;

    cur_req = "R1";  idle(300, 35, 0);
    cur_req = "R2";
    for (int k = 0; k < 270; k++) step(6'h3F, 0, 8'h00, 0, 2'd0, 8'h00);
    idle(20, 50, 0);
    cur_req = "R3";  wr(2'd0, 8'h08); idle(25, 60, 0); wr(2'd0, 8'h00); idle(30, 40, 0);
    cur_req = "R4";  wr(2'd0, 8'h10); idle(500, 30, 40);
    for (int k = 0; k < 300; k++) step(6'h3F, (k == 290), 8'h00, 0, 2'd0, 8'h00);
    idle(10, 20, 3); wr(2'd0, 8'h00); idle(20, 30, 0);
    cur_req = "R9";  wr(2'd1, 8'hA5);
    for (int k = 0; k < 150; k++)
      step(rnd_ev(20), 0, ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'h00,
           ($urandom_range(0, 19) == 0), 2'($urandom_range(1, 3)), 8'($urandom));
    cur_req = "R6";
    for (int k = 0; k < 60; k++) step(0, 0, 8'h01 << (k % 8), 0, 2'd2, 8'h00);
    cur_req = "R7";  wr(2'd1, 8'hFF); step(0, 0, 8'h00, 1, 2'd0, 8'h02);
    step(0, 0, 8'h40, 1, 2'd0, 8'h02); step(0, 0, 8'h10, 0, 2'd2, 8'h00);
    step(0, 0, 8'h00, 1, 2'd0, 8'h02); idle(3, 0, 0);
    cur_req = "R8";  step(0, 0, 8'h81, 0, 2'd2, 8'h00); wr(2'd0, 8'h04);
    for (int k = 0; k < 40; k++) step(rnd_ev(20), 0, 8'($urandom), 0, 2'd2, 8'h00);
    wr(2'd0, 8'h00); step(0, 0, 8'h02, 0, 2'd2, 8'h00);
    cur_req = "R5";  wr(2'd0, 8'h30); wr(2'd1, 8'hFF); step(0, 0, 8'h33, 0, 2'd2, 8'h00);
    step(6'h3F, 0, 8'h00, 1, 2'd0, 8'h01);
    step(6'h3F, 0, 8'hFF, 1, 2'd0, 8'h3C);
    step(6'h3F, 0, 8'h00, 1, 2'd1, 8'hFF);
    step(6'h3F, 0, 8'h00, 0, 2'd0, 8'h00);
    step(6'h3F, 0, 8'h00, 0, 2'd0, 8'h00);
    idle(4, 50, 0); wr(2'd0, 8'h03); idle(8, 30, 0);
    cur_req = "R10"; wr(2'd0, 8'h20); idle(40, 20, 0); wr(2'd0, 8'h00); idle(40, 20, 0);
    cur_req = "R12"; step(0, 0, 8'h00, 1, 2'd2, 8'hFF); step(0, 0, 8'h00, 1, 2'd3, 8'hFF);
    idle(8, 10, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule